// File: doc/BRIEF.md
# DMA Address Translation Table

This block translates the I/O addresses issued by DMA-capable devices into system physical addresses through one flat table of 64-bit entries held on chip. The I/O address is split into a page number and a page offset. The page number selects an entry. The entry supplies the physical page base and a 2-bit access code in its two lowest bits. A lookup returns five things: the page-aligned I/O address, the translated page base, the offset mask, the access code, and a fault flag for the requested direction. It also returns the composed physical address.

Lookups enter through a valid/ready request channel and leave through a registered valid/ready response channel, one cycle later. An update engine writes and reads entries by index through a separate port. Reset clears the whole table, so every page faults until software fills it in.

Top module: `dxt_table`

## Requirements
- R1: For an in-bounds lookup, `rsp_iova` is `req_addr` with its low PAGE_SHIFT bits cleared, and `rsp_mask` equals 2^PAGE_SHIFT − 1.
- R2: The page index is `req_addr >> PAGE_SHIFT`. When this index is at or above NUM_ENTRIES, the response gives zero `rsp_iova`, zero `rsp_base`, an all-ones `rsp_mask`, `rsp_perm` = 0 and `rsp_fault` = 1.
- R3: For an in-bounds lookup, `rsp_base` is the selected entry with its low PAGE_SHIFT bits cleared. For every lookup, `rsp_phys` equals `rsp_base | (req_addr & rsp_mask)`.
- R4: `rsp_perm` is bits [1:0] of the selected entry, encoded as 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R5: `rsp_fault` is 1 when a write (`req_write` = 1) meets a code with bit 1 clear, or when a read meets a code with bit 0 clear. Otherwise it is 0.
- R6: Reset sets every entry to zero and leaves `rsp_valid` = 0, `req_ready` = 1 and `upd_rdata` = 0. A reset applied mid-run wipes entries that were written earlier.
- R7: A request accepted on a rising edge (`req_valid` and `req_ready` both high) shows `rsp_valid` = 1 after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. A response that is not taken holds all of its fields stable. Responses leave in acceptance order.
- R8: When the update port writes the entry that a lookup selects on the same edge, that lookup returns the value the entry held before the write. The next lookup returns the new value.
- R9: `upd_en` with `upd_we` = 1 writes `upd_wdata` to entry `upd_idx`. `upd_en` with `upd_we` = 0 puts that entry on `upd_rdata` after the edge. An index at or above NUM_ENTRIES ignores the write and reads back zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | ADDR_W | Device I/O address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_iova | output | ADDR_W | Page-aligned I/O address |
| rsp_base | output | ENTRY_W | Translated page base |
| rsp_mask | output | ENTRY_W | Page offset mask |
| rsp_phys | output | ENTRY_W | Composed physical address |
| rsp_perm | output | 2 | Access code |
| rsp_fault | output | 1 | Requested direction not permitted |
| upd_en | input | 1 | Update port access strobe |
| upd_we | input | 1 | 1 = write entry, 0 = read entry |
| upd_idx | input | clog2(NUM_ENTRIES) | Entry index |
| upd_wdata | input | ENTRY_W | Entry write data |
| upd_rdata | output | ENTRY_W | Entry read data, registered |

## Verification
The assertions check these properties on every cycle:
- the response shape: the mask is one of its two legal forms, and out-of-range replies carry zeros and a fault;
- page alignment of the I/O address and of the base;
- the split of the physical address into base and offset;
- the link between access code and fault for the extreme codes;
- handshake timing and the stability of a stalled response;
- zero read-back for out-of-range indices.

Other behaviours only the bench scenarios can show:
- the actual entry contents behind each translation;
- the direction-dependent faults of the read-only and write-only codes;
- the last valid page against the first out-of-range page;
- the old-value result of a same-edge update;
- the wipe caused by a mid-run reset.

// File: rtl/dxt_pkg.sv
package dxt_pkg;

  // Access code carried in bits [1:0] of each table entry.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2,
    ACC_RDWR = 2'd3
  } acc_code_e;

  // True when the access code permits the requested direction.
  function automatic logic acc_permits(input logic [1:0] code, input logic is_write);
    return is_write ? code[1] : code[0];
  endfunction

endpackage

// File: rtl/dxt_entry_store.sv
// Flop-based entry array: one write/read port for the update engine,
// one combinational read port for the lookup path.
module dxt_entry_store #(
  parameter int NUM_ENTRIES = 48,
  parameter int ENTRY_W     = 64,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic               upd_we,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [ENTRY_W-1:0] upd_wdata,
  output logic [ENTRY_W-1:0] upd_rdata,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [ENTRY_W-1:0] lk_data
);

  logic [ENTRY_W-1:0] ent_q [NUM_ENTRIES];
  logic [ENTRY_W-1:0] upd_sel;
  logic [ENTRY_W-1:0] rd_d, rd_q;

  // One register per entry with its own write enable.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic wr_hit;
    assign wr_hit = upd_en && upd_we && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_hit) begin
        ent_q[g] <= upd_wdata;
      end
    end
  end

  // Read multiplexers; an index beyond the table selects zero.
  always_comb begin
    lk_data = '0;
    upd_sel = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lk_idx == IDX_W'(i))  lk_data = ent_q[i];
      if (upd_idx == IDX_W'(i)) upd_sel = ent_q[i];
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (upd_en && !upd_we) rd_d = upd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign upd_rdata = rd_q;

endmodule

// File: rtl/dxt_xlate_core.sv
// Combinational translation: page split, bound check and result shaping.
module dxt_xlate_core
  import dxt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 48,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_write,
  output logic [IDX_W-1:0]   lk_idx,
  input  logic [ENTRY_W-1:0] entry,
  output logic [ADDR_W-1:0]  iova,
  output logic [ENTRY_W-1:0] base,
  output logic [ENTRY_W-1:0] mask,
  output logic [ENTRY_W-1:0] phys,
  output logic [1:0]         perm,
  output logic               fault
);

  localparam int PN_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ENTRY_W-1:0] OFS_MASK =
    {{(ENTRY_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [ADDR_W-1:0] IOVA_OFS = OFS_MASK[ADDR_W-1:0];

  logic [PN_W-1:0]    page_no;
  logic               in_bound;
  logic [ENTRY_W-1:0] addr_ext;

  assign page_no  = addr[ADDR_W-1:PAGE_SHIFT];
  assign in_bound = page_no < PN_W'(NUM_ENTRIES);
  assign lk_idx   = page_no[IDX_W-1:0];
  assign addr_ext = ENTRY_W'(addr);

  always_comb begin
    if (in_bound) begin
      iova = addr & ~IOVA_OFS;
      base = entry & ~OFS_MASK;
      mask = OFS_MASK;
      perm = entry[1:0];
    end else begin
      iova = '0;
      base = '0;
      mask = '1;
      perm = ACC_NONE;
    end
    fault = !acc_permits(perm, is_write);
    phys  = base | (addr_ext & mask);
  end

endmodule

// File: rtl/dxt_rsp_stage.sv
// One registered response slot with valid/ready on both sides.
module dxt_rsp_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  output logic              can_push,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] dout
);

  logic              vld_d, vld_q;
  logic [DATA_W-1:0] dat_d, dat_q;
  logic              dat_en;

  assign can_push = !vld_q || out_ready;
  assign dat_en   = push;

  always_comb begin
    vld_d = vld_q;
    if (push)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    dat_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  assign out_valid = vld_q;
  assign dout      = dat_q;

endmodule

// File: rtl/dxt_table.sv
// DMA address translation table top level.
module dxt_table #(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 48
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           req_write,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [ADDR_W-1:0]              rsp_iova,
  output logic [ENTRY_W-1:0]             rsp_base,
  output logic [ENTRY_W-1:0]             rsp_mask,
  output logic [ENTRY_W-1:0]             rsp_phys,
  output logic [1:0]                     rsp_perm,
  output logic                           rsp_fault,
  input  logic                           upd_en,
  input  logic                           upd_we,
  input  logic [$clog2(NUM_ENTRIES)-1:0] upd_idx,
  input  logic [ENTRY_W-1:0]             upd_wdata,
  output logic [ENTRY_W-1:0]             upd_rdata
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int RSP_W = ADDR_W + 3 * ENTRY_W + 3;

  logic [IDX_W-1:0]   lk_idx;
  logic [ENTRY_W-1:0] lk_data;
  logic [ADDR_W-1:0]  x_iova;
  logic [ENTRY_W-1:0] x_base, x_mask, x_phys;
  logic [1:0]         x_perm;
  logic               x_fault;
  logic               accept;
  logic [RSP_W-1:0]   rsp_din, rsp_dout;

  dxt_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_we(upd_we), .upd_idx(upd_idx),
    .upd_wdata(upd_wdata), .upd_rdata(upd_rdata),
    .lk_idx(lk_idx), .lk_data(lk_data)
  );

  dxt_xlate_core #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
  ) u_core (
    .addr(req_addr), .is_write(req_write), .lk_idx(lk_idx), .entry(lk_data),
    .iova(x_iova), .base(x_base), .mask(x_mask), .phys(x_phys),
    .perm(x_perm), .fault(x_fault)
  );

  assign accept  = req_valid && req_ready;
  assign rsp_din = {x_iova, x_base, x_mask, x_phys, x_perm, x_fault};

  dxt_rsp_stage #(.DATA_W(RSP_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .din(rsp_din), .can_push(req_ready),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .dout(rsp_dout)
  );

  assign {rsp_iova, rsp_base, rsp_mask, rsp_phys, rsp_perm, rsp_fault} = rsp_dout;

endmodule

// File: rtl/dxt_table_chk.sv
module dxt_table_chk #(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 48
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic                           rsp_valid,
  input logic                           rsp_ready,
  input logic [ADDR_W-1:0]              rsp_iova,
  input logic [ENTRY_W-1:0]             rsp_base,
  input logic [ENTRY_W-1:0]             rsp_mask,
  input logic [ENTRY_W-1:0]             rsp_phys,
  input logic [1:0]                     rsp_perm,
  input logic                           rsp_fault,
  input logic                           upd_en,
  input logic                           upd_we,
  input logic [$clog2(NUM_ENTRIES)-1:0] upd_idx,
  input logic [ENTRY_W-1:0]             upd_rdata
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [ENTRY_W-1:0] OFS_MASK =
    {{(ENTRY_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [ADDR_W-1:0] IOVA_OFS = OFS_MASK[ADDR_W-1:0];

  a_r7_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_iova) && $stable(rsp_base)
      && $stable(rsp_mask) && $stable(rsp_phys) && $stable(rsp_perm) && $stable(rsp_fault)));

  a_r7_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  a_r1_inbound_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask != '1) |-> (rsp_mask == OFS_MASK && (rsp_iova & IOVA_OFS) == '0));

  a_r2_oob_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask == '1) |-> (rsp_iova == '0 && rsp_base == '0
      && rsp_perm == 2'd0 && rsp_fault));

  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_base & OFS_MASK) == '0);

  a_r3_phys_split: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_phys & ~rsp_mask) == rsp_base);

  a_r5_rdwr_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 2'd3) |-> !rsp_fault);

  a_r5_none_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 2'd0) |-> rsp_fault);

  a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_we && upd_idx >= IDX_W'(NUM_ENTRIES)) |=> upd_rdata == '0);

endmodule

bind dxt_table dxt_table_chk #(
  .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova),
  .rsp_base(rsp_base), .rsp_mask(rsp_mask), .rsp_phys(rsp_phys),
  .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .upd_en(upd_en), .upd_we(upd_we),
  .upd_idx(upd_idx), .upd_rdata(upd_rdata)
);

// File: tb/dxt_table_test.sv
`timescale 1ns/1ps
module dxt_table_test;

  localparam int AW = 32;
  localparam int EW = 64;
  localparam int PS = 12;
  localparam int NE = 48;
  localparam int IW = $clog2(NE);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, rsp_ready;
  logic          req_ready, rsp_valid, rsp_fault;
  logic [AW-1:0] req_addr, rsp_iova;
  logic [EW-1:0] rsp_base, rsp_mask, rsp_phys;
  logic [1:0]    rsp_perm;
  logic          upd_en, upd_we;
  logic [IW-1:0] upd_idx;
  logic [EW-1:0] upd_wdata, upd_rdata;

  always #2 clk = ~clk;

  dxt_table #(.ADDR_W(AW), .ENTRY_W(EW), .PAGE_SHIFT(PS), .NUM_ENTRIES(NE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_base(rsp_base),
    .rsp_mask(rsp_mask), .rsp_phys(rsp_phys), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault), .upd_en(upd_en), .upd_we(upd_we), .upd_idx(upd_idx),
    .upd_wdata(upd_wdata), .upd_rdata(upd_rdata)
  );

  typedef struct {
    logic [AW-1:0] iova;
    logic [EW-1:0] base;
    logic [EW-1:0] mask;
    logic [EW-1:0] phys;
    logic [1:0]    perm;
    logic          fault;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [EW-1:0] model [NE];
  int            checks = 0;
  int            failures = 0;
  bit            bp_mode = 1'b0;
  bit            finished = 1'b0;
  int            cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [EW-1:0] act,
                       input logic [EW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Expected response built from the requirements.
  function automatic exp_t predict(input logic [AW-1:0] a, input logic wr, input string tag);
    exp_t e;
    int unsigned pg;
    pg = a >> PS;
    e.tag = tag;
    if (pg < NE) begin
      e.iova = a & ~((32'd1 << PS) - 1);
      e.mask = (64'd1 << PS) - 1;
      e.base = model[pg] & ~e.mask;
      e.perm = model[pg][1:0];
    end else begin
      e.iova = '0;
      e.mask = '1;
      e.base = '0;
      e.perm = 2'd0;
    end
    e.fault = wr ? !e.perm[1] : !e.perm[0];
    e.phys  = e.base | ({32'd0, a} & e.mask);
    return e;
  endfunction

  // Consumer-side ready pattern.
  initial begin
    rsp_ready = 1'b1;
    forever begin
      @(negedge clk);
      rsp_ready = bp_mode ? (cyc % 3 != 2) : 1'b1;
      cyc++;
    end
  end

  // Monitor: pops one expected item per response taken.
  initial begin
    forever begin
      @(negedge clk);
      #0.4;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected response", {32'd0, rsp_iova}, '0);
        end else begin
          exp_t e;
          bit ok;
          e = exp_q.pop_front();
          ok = (rsp_iova == e.iova) && (rsp_base == e.base) && (rsp_mask == e.mask)
            && (rsp_phys == e.phys) && (rsp_perm == e.perm) && (rsp_fault == e.fault);
          checks++;
          if (!ok) begin
            failures++;
            $display("FAIL %s actual iova=%h base=%h mask=%h phys=%h perm=%0d fault=%0b expected iova=%h base=%h mask=%h phys=%h perm=%0d fault=%0b",
                     e.tag, rsp_iova, rsp_base, rsp_mask, rsp_phys, rsp_perm, rsp_fault,
                     e.iova, e.base, e.mask, e.phys, e.perm, e.fault);
          end
        end
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input logic wr, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    #0.2;
    while (!req_ready) begin
      @(negedge clk);
      #0.2;
    end
    exp_q.push_back(predict(a, wr, tag));
    @(posedge clk);
    #0.1;
    req_valid = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [EW-1:0] d);
    @(negedge clk);
    upd_en = 1'b1; upd_we = 1'b1; upd_idx = IW'(idx); upd_wdata = d;
    @(posedge clk);
    #0.1;
    upd_en = 1'b0;
    if (idx < NE) model[idx] = d;
  endtask

  task automatic get_entry(input int idx, input logic [EW-1:0] expv, input string tag);
    @(negedge clk);
    upd_en = 1'b1; upd_we = 1'b0; upd_idx = IW'(idx);
    @(posedge clk);
    #0.1;
    upd_en = 1'b0;
    #0.4;
    check(upd_rdata == expv, tag, upd_rdata, expv);
  endtask

  task automatic drain();
    for (int i = 0; i < 100; i++) begin
      if (exp_q.size() == 0 && !rsp_valid) break;
      @(negedge clk);
      #0.6;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    upd_en = 1'b0; upd_we = 1'b0; upd_idx = '0; upd_wdata = '0;
    for (int i = 0; i < NE; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;

    // R6: reset state
    check(req_ready == 1'b1, "R6 req_ready after reset", {63'd0, req_ready}, 64'd1);
    check(rsp_valid == 1'b0, "R6 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check(upd_rdata == '0, "R6 upd_rdata after reset", upd_rdata, 64'd0);
    lookup(32'h0000_0123, 1'b0, "R6 cleared page faults on read");
    lookup(32'h0002_F456, 1'b1, "R6 cleared last page faults on write");
    get_entry(47, 64'd0, "R6 last entry cleared");
    drain();

    // R9: fill entries through the update port
    put_entry(1,  64'h0000_0012_3456_7001);
    put_entry(2,  64'h0000_0000_8000_2FFE);
    put_entry(3,  64'h0000_00AB_CDEF_0003);
    put_entry(4,  64'hDEAD_BEEF_0000_0FFC);
    put_entry(47, 64'hFFFF_FFFF_FFFF_F003);
    get_entry(1,  64'h0000_0012_3456_7001, "R9 read back entry 1");
    get_entry(4,  64'hDEAD_BEEF_0000_0FFC, "R9 read back entry 4");
    put_entry(50, 64'h1111_2222_3333_4003);
    get_entry(50, 64'd0, "R9 out-of-range index reads zero");
    get_entry(47, 64'hFFFF_FFFF_FFFF_F003, "R9 out-of-range write leaves table intact");

    // R1, R3, R4, R5: translations for each access code
    lookup(32'h0000_1ABC, 1'b0, "R4 read-only page read");
    lookup(32'h0000_1ABC, 1'b1, "R5 read-only page write faults");
    lookup(32'h0000_2004, 1'b1, "R4 write-only page write");
    lookup(32'h0000_2FFF, 1'b0, "R5 write-only page read faults");
    lookup(32'h0000_3800, 1'b0, "R3 read-write page read");
    lookup(32'h0000_3001, 1'b1, "R3 read-write page write");
    lookup(32'h0000_4FF0, 1'b0, "R5 no-access code faults");
    lookup(32'h0002_FFFF, 1'b1, "R1 last in-range page");

    // R2: first page past the table and top of the address space
    lookup(32'h0003_0000, 1'b0, "R2 first page past bound");
    lookup(32'hFFFF_F123, 1'b1, "R2 top address out of bound");
    drain();

    // R7: one-cycle latency
    lookup(32'h0000_3010, 1'b0, "R7 latency item");
    #0.5;
    check(rsp_valid == 1'b1, "R7 response valid one cycle after accept", {63'd0, rsp_valid}, 64'd1);
    drain();

    // R7: back-to-back traffic under back-pressure, order preserved
    bp_mode = 1'b1;
    for (int k = 0; k < 24; k++) begin
      lookup(AW'((k % 6) << PS) | AW'(k * 37), k[0], "R7 ordered under back-pressure");
    end
    drain();
    bp_mode = 1'b0;
    drain();

    // R8: same-edge update and lookup of entry 1
    @(negedge clk);
    upd_en = 1'b1; upd_we = 1'b1; upd_idx = IW'(1); upd_wdata = 64'h0000_0077_0000_1003;
    req_valid = 1'b1; req_addr = 32'h0000_1010; req_write = 1'b1;
    #0.2;
    while (!req_ready) begin
      @(negedge clk);
      #0.2;
    end
    exp_q.push_back(predict(32'h0000_1010, 1'b1, "R8 lookup sees old entry"));
    @(posedge clk);
    #0.1;
    upd_en = 1'b0;
    req_valid = 1'b0;
    model[1] = 64'h0000_0077_0000_1003;
    lookup(32'h0000_1010, 1'b1, "R8 next lookup sees new entry");
    drain();

    // R6: mid-run reset wipes the table
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NE; i++) model[i] = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check(rsp_valid == 1'b0, "R6 rsp_valid after mid-run reset", {63'd0, rsp_valid}, 64'd0);
    get_entry(3, 64'd0, "R6 entry wiped by mid-run reset");
    lookup(32'h0000_3800, 1'b0, "R6 wiped page faults");
    drain();

    check(exp_q.size() == 0, "R7 all responses delivered", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule